// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sequences the power modes of a small microcontroller. Four mode bits, taken from the processor status word, select one of six operating modes: the active mode or one of five low-power modes. The block turns the selected mode into registered gate enables. There is one enable for each of the following: the CPU core, the main clock, the sub-main (peripheral) clock, the auxiliary clock, the DC generator of the digitally controlled oscillator, and the crystal oscillator.

When an interrupt is pending, the block leaves any low-power mode, enters active mode and remembers the mode it left. It stays in active mode until the interrupt-return strobe, then puts the remembered mode back. A further input reports whether the controlled oscillator drives the main clock. That input decides whether the generator stays powered in the lightest mode that stops the core.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: Reset gives mode code 0 (active) with all six enables high.
- R2: Mode decode has a fixed priority. With `sr_halt`=0 the mode is active (code 0), whatever the other bits are. With `sr_halt`=1 and `sr_xtal_off`=1 the mode is LPM4 (code 5). Otherwise {`sr_sub_off`,`sr_gen_off`} = 00, 01, 10, 11 give LPM0..LPM3 (codes 1..4).
- R3: In every mode other than active, `core_en` and `main_clk_en` are both low. In active mode all six enables are high.
- R4: LPM0 keeps the sub-main clock, the auxiliary clock, the generator and the crystal enabled.
- R5: LPM1 keeps the sub-main clock, the auxiliary clock and the crystal enabled. In LPM1 `dcgen_en` equals `dco_feeds_main`.
- R6: LPM2 disables the sub-main clock and keeps the auxiliary clock, the generator and the crystal enabled. LPM3 is the same as LPM2, except that the generator is also disabled.
- R7: LPM4 drives all six enables low.
- R8: Enables and mode code are registered. A change of the mode bits shows on the outputs after the next rising clock edge.
- R9: `irq_pend` high in a low-power mode gives active mode after the next edge. Active mode holds, whatever the mode bits do, until the cycle after `irq_ret`.
- R10: `irq_ret` during a wake restores the low-power mode that was left, after the next edge.
- R11: If `irq_pend` and `irq_ret` are both high in the same cycle during a wake, the block stays in active mode and keeps the saved mode for the next return.
- R12: `irq_ret` has no effect when no wake is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_halt | input | 1 | Mode bit: stop the core |
| sr_xtal_off | input | 1 | Mode bit: stop the crystal |
| sr_gen_off | input | 1 | Mode bit: clock group 0 off |
| sr_sub_off | input | 1 | Mode bit: clock group 1 off |
| irq_pend | input | 1 | Interrupt request pending |
| irq_ret | input | 1 | Interrupt-return strobe |
| dco_feeds_main | input | 1 | Controlled oscillator sources the main clock |
| core_en | output | 1 | CPU core enable |
| main_clk_en | output | 1 | Main clock gate enable |
| sub_clk_en | output | 1 | Sub-main clock gate enable |
| aux_clk_en | output | 1 | Auxiliary clock gate enable |
| dcgen_en | output | 1 | Oscillator DC generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| mode_code | output | 3 | Current mode, 0 active, 1..5 LPM0..LPM4 |

## Verification
An error in the wake flag shows one edge after the failing cycle. If the flag is lost, the core is disabled while an interrupt is being serviced. If the flag is stuck, the block never reaches a low-power mode again. A corrupt saved mode shows on `mode_code` one edge after the return strobe, so the bench compares the mode after each return with the mode held before the wake. Gating errors show in the enable vector on the edge after the mode bits change.

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sr_halt,
  input  logic       sr_xtal_off,
  input  logic       sr_gen_off,
  input  logic       sr_sub_off,
  input  logic       irq_pend,
  input  logic       irq_ret,
  input  logic       dco_feeds_main,
  output logic       core_en,
  output logic       main_clk_en,
  output logic       sub_clk_en,
  output logic       aux_clk_en,
  output logic       dcgen_en,
  output logic       xtal_en,
  output logic [2:0] mode_code
);
  localparam logic [2:0] M_ACT = 3'd0;
  localparam logic [2:0] M_L0  = 3'd1;
  localparam logic [2:0] M_L1  = 3'd2;
  localparam logic [2:0] M_L2  = 3'd3;
  localparam logic [2:0] M_L3  = 3'd4;
  localparam logic [2:0] M_L4  = 3'd5;

  logic [2:0] req_mode, nxt_mode, saved_q, nxt_saved, cur_q;
  logic       wake_q, nxt_wake;
  logic [5:0] gate_q, nxt_gate;

  always_comb begin
    if (!sr_halt)         req_mode = M_ACT;
    else if (sr_xtal_off) req_mode = M_L4;
    else case ({sr_sub_off, sr_gen_off})
      2'b00:   req_mode = M_L0;
      2'b01:   req_mode = M_L1;
      2'b10:   req_mode = M_L2;
      default: req_mode = M_L3;
    endcase
  end

  always_comb begin
    nxt_wake  = wake_q;
    nxt_saved = saved_q;
    nxt_mode  = req_mode;
    if (wake_q) begin
      nxt_mode = M_ACT;
      if (irq_ret && !irq_pend) begin
        nxt_wake = 1'b0;
        nxt_mode = saved_q;
      end
    end else if (irq_pend && req_mode != M_ACT) begin
      nxt_wake  = 1'b1;
      nxt_saved = req_mode;
      nxt_mode  = M_ACT;
    end
  end

  // order: core, main, sub, aux, generator, crystal
  always_comb begin
    case (nxt_mode)
      M_ACT:   nxt_gate = 6'b111111;
      M_L0:    nxt_gate = 6'b001111;
      M_L1:    nxt_gate = {4'b0011, dco_feeds_main, 1'b1};
      M_L2:    nxt_gate = 6'b000111;
      M_L3:    nxt_gate = 6'b000101;
      default: nxt_gate = 6'b000000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= M_ACT;
      saved_q <= M_ACT;
      wake_q  <= 1'b0;
      gate_q  <= 6'b111111;
    end else begin
      cur_q   <= nxt_mode;
      saved_q <= nxt_saved;
      wake_q  <= nxt_wake;
      gate_q  <= nxt_gate;
    end
  end

  assign {core_en, main_clk_en, sub_clk_en, aux_clk_en, dcgen_en, xtal_en} = gate_q;
  assign mode_code = cur_q;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_pend,
  input logic       core_en,
  input logic       main_clk_en,
  input logic       sub_clk_en,
  input logic       aux_clk_en,
  input logic       dcgen_en,
  input logic       xtal_en,
  input logic [2:0] mode_code
);
  a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code <= 3'd5);
  a_r3_core_main_paired: assert property (@(posedge clk) disable iff (!rst_n)
    core_en == main_clk_en);
  a_r3_active_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0) |-> (core_en && main_clk_en && sub_clk_en && aux_clk_en && dcgen_en && xtal_en));
  a_r3_low_core_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != 3'd0) |-> !core_en);
  a_r7_xtal_off_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en |-> (!aux_clk_en && !sub_clk_en && !dcgen_en && mode_code == 3'd5));
  a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && mode_code != 3'd0) |=> (mode_code == 3'd0));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend),
  .core_en(core_en), .main_clk_en(main_clk_en), .sub_clk_en(sub_clk_en),
  .aux_clk_en(aux_clk_en), .dcgen_en(dcgen_en), .xtal_en(xtal_en),
  .mode_code(mode_code)
);

// File: tb/tb_lpm_clk_ctrl.sv
module tb_lpm_clk_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic halt = 0, xoff = 0, goff = 0, soff = 0, pend = 0, ret = 0, dco = 1;
  logic core_en, main_clk_en, sub_clk_en, aux_clk_en, dcgen_en, xtal_en;
  logic [2:0] mode_code;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_clk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sr_halt(halt), .sr_xtal_off(xoff),
    .sr_gen_off(goff), .sr_sub_off(soff), .irq_pend(pend), .irq_ret(ret),
    .dco_feeds_main(dco), .core_en(core_en), .main_clk_en(main_clk_en),
    .sub_clk_en(sub_clk_en), .aux_clk_en(aux_clk_en), .dcgen_en(dcgen_en),
    .xtal_en(xtal_en), .mode_code(mode_code)
  );

  function automatic logic [5:0] exp_gates(input int m, input logic d);
    case (m)
      0: return 6'b111111;
      1: return 6'b001111;
      2: return {4'b0011, d, 1'b1};
      3: return 6'b000111;
      4: return 6'b000101;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int m, input logic d);
    logic [5:0] g;
    g = {core_en, main_clk_en, sub_clk_en, aux_clk_en, dcgen_en, xtal_en};
    checks++;
    if (mode_code != 3'(m) || g != exp_gates(m, d)) begin
      errors++;
      $display("FAIL %s: mode=%0d gates=%b expected mode=%0d gates=%b",
               req, mode_code, g, m, exp_gates(m, d));
    end
  endtask

  task automatic set_bits(input logic h, input logic x, input logic s1, input logic s0);
    halt = h; xoff = x; soff = s1; goff = s0;
  endtask

  task automatic t_reset();
    set_bits(1, 1, 1, 1);
    rst_n = 0;
    #(CLK_PERIOD*2);
    @(negedge clk);
    check("R1", 0, 1);
    rst_n = 1;
    set_bits(0, 0, 0, 0);
    step();
    check("R1", 0, 1);
  endtask

  task automatic t_modes();
    for (int k = 0; k < 4; k++) begin
      set_bits(1, 0, k[1], k[0]);
      step();
      check(k == 0 ? "R4" : k == 1 ? "R5" : "R6", k + 1, dco);
    end
    set_bits(1, 1, 0, 1);
    step();
    check("R7", 5, dco);
    set_bits(0, 1, 1, 1);
    step();
    check("R2", 0, dco);
  endtask

  task automatic t_registered();
    set_bits(1, 0, 1, 0);
    #1;
    check("R8", 0, dco);
    step();
    check("R8", 3, dco);
    set_bits(0, 0, 0, 0);
    step();
  endtask

  task automatic t_lpm1_dco();
    dco = 0;
    set_bits(1, 0, 0, 1);
    step();
    check("R5", 2, 0);
    dco = 1;
    step();
    check("R5", 2, 1);
    set_bits(0, 0, 0, 0);
    step();
  endtask

  task automatic t_wake_return();
    set_bits(1, 0, 1, 1);
    step();
    check("R6", 4, dco);
    pend = 1;
    step();
    check("R9", 0, dco);
    pend = 0;
    set_bits(1, 1, 0, 0);
    step();
    check("R9", 0, dco);
    ret = 1;
    step();
    ret = 0;
    check("R10", 4, dco);
    set_bits(0, 0, 0, 0);
    step();
  endtask

  task automatic t_wake_wins();
    set_bits(1, 0, 1, 0);
    step();
    pend = 1;
    step();
    check("R9", 0, dco);
    ret = 1;
    step();
    check("R11", 0, dco);
    pend = 0;
    step();
    ret = 0;
    check("R11", 3, dco);
    set_bits(0, 0, 0, 0);
    step();
  endtask

  task automatic t_stray_ret();
    ret = 1;
    step();
    ret = 0;
    check("R12", 0, dco);
    set_bits(1, 0, 0, 0);
    ret = 1;
    step();
    ret = 0;
    check("R12", 1, dco);
    set_bits(0, 0, 0, 0);
    step();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_modes();
        t_registered();
        t_lpm1_dco();
        t_wake_return();
        t_wake_wins();
        t_stray_ret();
      end
      begin
        #(CLK_PERIOD*5000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule